// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block supplies the per-round 32-bit schedule word of SHA-1 for one 512-bit block. A producer feeds the sixteen block words one per cycle on a load port. After the sixteenth word has been accepted, the block presents round word 0 on its output. Each step strobe from the round engine then moves the output to the next round word, up to and including word 79. After the last word is consumed, the output-valid flag drops. It stays low until a fresh block has been loaded.

Only sixteen words are stored. The window holds the current word and the fifteen that follow it. On every advance the window shifts down by one position. The word that enters at the top is either the next loaded block word or, once the block is fully loaded, the recurrence word. The recurrence word is the XOR of four window entries, rotated left by one bit. Byte-order conversion is done upstream, as are message padding, the compression rounds and the digest update.

Top module: `sha1_wsched`

## Requirements
- R1: Each cycle with `load_valid` high accepts `load_word` as the next block word, taken as-is (bit 31 is the most significant bit, the first message byte in big-endian order). On the cycle after the sixteenth word is accepted, `w_valid` is 1 and `w_out` equals the first word accepted.
- R2: For steps 0 to 15, `w_out` equals the loaded block words in the order they were accepted.
- R3: For steps 16 to 79, `w_out` equals the XOR of the words of steps t-16, t-14, t-8 and t-3, rotated left by one bit (bit 31 moves to bit 0).
- R4: A high `step` while `w_valid` is high and `load_valid` is low advances `w_out` to the next step's word on the following cycle. While `step` is low, `w_out` and `w_valid` hold.
- R5: Exactly 80 words are produced per block. After the step that consumes word 79, `w_valid` is low on the next cycle. A `step` while `w_valid` is low has no effect: `w_valid` stays low, and the next loaded block still starts at its word 0.
- R6: A `load_valid` at any time starts a new block. From the next cycle, `w_valid` is low until all sixteen words of the new block are accepted. `load_valid` takes precedence over `step` in the same cycle.
- R7: While `rst_n` is low at a clock edge, the block returns to idle. After reset, `w_valid` is 0 and `w_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Accept `load_word` as the next block word |
| load_word | input | WORD_W | Block word, already in big-endian order |
| step | input | 1 | Advance to the next round word |
| w_out | output | WORD_W | Schedule word of the current step |
| w_valid | output | 1 | High while `w_out` holds one of the 80 round words |

## Verification
The bench builds the block with its defaults: 32-bit words and 80 steps. At these values every tap position of the recurrence takes part, and every word from 16 to 79 depends on all four distances. The cut-off after word 79 is therefore reached exactly where SHA-1 places it. The blocks used have a known short-message pattern, all ones, a single set bit, a counting pattern and a pseudo-random fill. Steps are issued with and without idle gaps. A block is restarted in mid-run. Strobes are sent while idle and while loading.

// File: rtl/sha1_ws_pkg.sv
// Package: shared constants and types of the SHA-1 schedule generator.
// Assumes: the tap distances are those of the SHA-1 recurrence; the
// window depth equals the largest distance, so the window covers W[t..t+15].
package sha1_ws_pkg;

    // Distances back from the word being generated.
    localparam int TAP_NEAR  = 3;
    localparam int TAP_MID   = 8;
    localparam int TAP_FAR   = 14;
    localparam int TAP_OLD   = 16;

    // Window depth follows from the oldest tap.
    localparam int WIN_DEPTH = TAP_OLD;

    // Left-rotation applied to the XOR of the taps.
    localparam int ROT_LEFT  = 1;

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } ws_state_t;

endpackage

// File: rtl/sha1_ws_window.sv
// Module: sha1_ws_window
// A DEPTH-entry shift register of words. Entry 0 is the oldest word
// (the one presented as the current round word). On shift_en, every
// entry takes the value of the one above it, and the top entry takes in_word.
// Assumes: DEPTH >= 2. Reset clears all entries to zero.
module sha1_ws_window #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] win [DEPTH]
);

    localparam int TOP = DEPTH - 1;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_entry
            if (gi == TOP) begin : g_top
                // Top entry: captures the incoming word on each shift.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        win[gi] <= '0;
                    end else if (shift_en) begin
                        win[gi] <= in_word;
                    end
                end
            end else begin : g_body
                // Lower entry: takes the word of its upper neighbour on each shift.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        win[gi] <= '0;
                    end else if (shift_en) begin
                        win[gi] <= win[gi+1];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sha1_ws_recur.sv
// Module: sha1_ws_recur
// Combinational recurrence. The window holds W[t..t+DEPTH-1] in entries
// 0..DEPTH-1. From it, this module forms W[t+DEPTH] as the XOR of the
// entries at each tap distance back from t+DEPTH, rotated left by ROT.
// Assumes: DEPTH equals the oldest tap distance, and 0 < ROT < WORD_W.
module sha1_ws_recur
    import sha1_ws_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = WIN_DEPTH,
    parameter int ROT    = ROT_LEFT
) (
    input  logic [WORD_W-1:0] win [DEPTH],
    output logic [WORD_W-1:0] next_word
);

    // Window indices of the taps relative to the word being produced.
    localparam int IDX_NEAR = DEPTH - TAP_NEAR;
    localparam int IDX_MID  = DEPTH - TAP_MID;
    localparam int IDX_FAR  = DEPTH - TAP_FAR;
    localparam int IDX_OLD  = DEPTH - TAP_OLD;

    logic [WORD_W-1:0] mixed;

    // XOR of the four taps.
    always_comb begin
        mixed = win[IDX_NEAR] ^ win[IDX_MID] ^ win[IDX_FAR] ^ win[IDX_OLD];
    end

    // Circular left rotation by ROT bits.
    always_comb begin
        next_word = {mixed[WORD_W-ROT-1:0], mixed[WORD_W-1:WORD_W-ROT]};
    end

endmodule

// File: rtl/sha1_ws_ctrl.sv
// Module: sha1_ws_ctrl
// Sequencer. It counts accepted block words during fill and the consumed
// round words during run. A load has priority over a step, and a load
// seen outside fill restarts the count at one. After DEPTH words it enters
// run at step 0. It leaves run after the step that consumes word NUM_STEPS-1.
// Assumes: DEPTH >= 2, NUM_STEPS >= 1.
module sha1_ws_ctrl
    import sha1_ws_pkg::*;
#(
    parameter int DEPTH     = WIN_DEPTH,
    parameter int NUM_STEPS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_valid,
    input  logic step,
    output logic shift_en,
    output logic sel_load,
    output logic run_valid
);

    localparam int LOAD_CW = $clog2(DEPTH);
    localparam int STEP_CW = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam logic [LOAD_CW-1:0] LOAD_LAST = LOAD_CW'(DEPTH - 1);
    localparam logic [STEP_CW-1:0] STEP_LAST = STEP_CW'(NUM_STEPS - 1);

    ws_state_t            state;
    logic [LOAD_CW-1:0]   load_cnt;
    logic [STEP_CW-1:0]   step_cnt;
    logic                 advance;

    // A step counts only in run and only without a competing load.
    always_comb begin
        advance = (state == ST_RUN) && step && !load_valid;
    end

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            load_cnt <= '0;
            step_cnt <= '0;
        end else if (load_valid) begin
            if (state != ST_FILL) begin
                state    <= ST_FILL;
                load_cnt <= LOAD_CW'(1);
            end else if (load_cnt == LOAD_LAST) begin
                state    <= ST_RUN;
                load_cnt <= '0;
                step_cnt <= '0;
            end else begin
                load_cnt <= load_cnt + LOAD_CW'(1);
            end
        end else if (advance) begin
            if (step_cnt == STEP_LAST) begin
                state    <= ST_IDLE;
                step_cnt <= '0;
            end else begin
                step_cnt <= step_cnt + STEP_CW'(1);
            end
        end
    end

    // Datapath controls and the output-valid flag.
    always_comb begin
        shift_en  = load_valid || advance;
        sel_load  = load_valid;
        run_valid = (state == ST_RUN);
    end

endmodule

// File: rtl/sha1_wsched.sv
// Module: sha1_wsched (top)
// SHA-1 message schedule generator. Sixteen block words are loaded one
// per cycle. Then W0..W(NUM_STEPS-1) are presented, one per step strobe.
// The window holds W[t..t+15], with W[t] on the output.
// Assumes: block words are already in big-endian order. Requires
// WORD_W >= 2.
module sha1_wsched
    import sha1_ws_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_STEPS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step,
    output logic [WORD_W-1:0] w_out,
    output logic              w_valid
);

    localparam int DEPTH = WIN_DEPTH;

    logic              shift_en;
    logic              sel_load;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] win [DEPTH];

    sha1_ws_ctrl #(
        .DEPTH     (DEPTH),
        .NUM_STEPS (NUM_STEPS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .step       (step),
        .shift_en   (shift_en),
        .sel_load   (sel_load),
        .run_valid  (w_valid)
    );

    sha1_ws_recur #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .ROT    (ROT_LEFT)
    ) u_recur (
        .win       (win),
        .next_word (next_word)
    );

    // Top-of-window source: a block word while loading, else the recurrence.
    always_comb begin
        in_word = sel_load ? load_word : next_word;
    end

    sha1_ws_window #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .in_word  (in_word),
        .win      (win)
    );

    // The oldest window entry is the current round word.
    always_comb begin
        w_out = win[0];
    end

endmodule

// File: rtl/sha1_wsched_chk.sv
// Module: sha1_wsched_chk
// Port-level checker for sha1_wsched, bound to every instance. It keeps
// its own count of the words consumed since the last load.
module sha1_wsched_chk #(
    parameter int WORD_W    = 32,
    parameter int NUM_STEPS = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_valid,
    input logic              step,
    input logic [WORD_W-1:0] w_out,
    input logic              w_valid
);

    logic [31:0] used;

    // Words consumed in the current run; cleared by any load.
    always_ff @(posedge clk) begin
        if (!rst_n || load_valid) begin
            used <= '0;
        end else if (w_valid && step) begin
            used <= used + 32'd1;
        end
    end

    // R1: output becomes valid only as the result of a load
    a_r1_valid_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_valid) |-> $past(load_valid));

    // R4: without a step or load, word and valid hold
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !step && !load_valid) |=> (w_valid && $stable(w_out)));

    // R5: never more than NUM_STEPS words in a run
    a_r5_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (used < NUM_STEPS));

    // R5: consuming the last word ends the run
    a_r5_end_of_block: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && step && !load_valid && used == NUM_STEPS - 1) |=> !w_valid);

    // R5: steps while idle cannot raise valid
    a_r5_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_valid && !load_valid) |=> !w_valid);

    // R6: a load during a run drops valid
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && load_valid) |=> !w_valid);

    // R7: right after reset the output is idle
    a_r7_reset: assert property (@(posedge clk)
        !rst_n |=> (!w_valid && w_out == '0));

endmodule

bind sha1_wsched sha1_wsched_chk #(
    .WORD_W    (WORD_W),
    .NUM_STEPS (NUM_STEPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .step       (step),
    .w_out      (w_out),
    .w_valid    (w_valid)
);

// File: tb/sim_sha1_wsched.sv
// Bench for sha1_wsched. A driver pushes each expected round word into a
// queue as it issues the step that consumes it. A monitor pops and compares
// at each consuming step. Expected words come from a full 80-word model.
module sim_sha1_wsched;

    localparam int W  = 32;
    localparam int NS = 80;

    typedef struct {
        logic [W-1:0] w;
        int           t;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [W-1:0] load_word = '0;
    logic         step = 1'b0;
    logic [W-1:0] w_out;
    logic         w_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int idx = 0;
    exp_t q[$];
    logic [W-1:0] blk [16];
    logic [W-1:0] ex [NS];

    sha1_wsched #(.WORD_W(W), .NUM_STEPS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .load_word(load_word), .step(step), .w_out(w_out), .w_valid(w_valid)
    );

    always #2 clk = ~clk;

    // Generic check with a requirement tag.
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exv);
        n_cmp++;
        if (act !== exv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exv);
        end
    endtask

    // Model: expected 80 words of the current block.
    task automatic build_expect();
        for (int t = 0; t < NS; t++) begin
            if (t < 16) ex[t] = blk[t];
            else begin
                logic [W-1:0] x;
                x = ex[t-3] ^ ex[t-8] ^ ex[t-14] ^ ex[t-16];
                ex[t] = {x[W-2:0], x[W-1]};
            end
        end
        idx = 0;
    endtask

    // Load the 16 words of blk, optionally with step held high (R6 priority).
    task automatic load_block(input logic step_too, input logic was_valid);
        build_expect();
        for (int i = 0; i < 16; i++) begin
            load_valid = 1'b1;
            load_word  = blk[i];
            step       = step_too;
            @(posedge clk); #1;
            if (i == 0 && was_valid) check("R6 valid drops on new load", {31'd0, w_valid}, 32'd0);
            if (i == 7) check("R6 valid low while filling", {31'd0, w_valid}, 32'd0);
        end
        load_valid = 1'b0;
        step = 1'b0;
        check("R1 valid after 16th word", {31'd0, w_valid}, 32'd1);
        check("R1 first word on output", w_out, blk[0]);
    endtask

    // Issue one consuming step, then idle for gap cycles checking hold.
    task automatic do_step(input int gap);
        exp_t e;
        e.w = ex[idx];
        e.t = idx;
        q.push_back(e);
        step = 1'b1;
        @(posedge clk); #1;
        step = 1'b0;
        idx++;
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            if (idx < NS) check("R4 hold without step", w_out, ex[idx]);
        end
    endtask

    // Run n steps with an optional gap pattern.
    task automatic run_steps(input int n, input logic gaps);
        for (int k = 0; k < n; k++) do_step(gaps ? ((k * 7) % 3) : 0);
    endtask

    // Checks after a complete block.
    task automatic end_checks();
        check("R5 valid low after word 79", {31'd0, w_valid}, 32'd0);
        step = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        step = 1'b0;
        check("R5 idle step ignored", {31'd0, w_valid}, 32'd0);
    endtask

    // Monitor: compare at each consuming step.
    always @(negedge clk) begin
        if (rst_n && w_valid && step && !load_valid) begin
            if (q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R5: actual extra word %h expected none", w_out);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.t < 16 ? "R2 block word" : "R3 recurrence word", w_out, e.w);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lf;
        repeat (3) @(posedge clk);
        #1;
        check("R7 valid low in reset", {31'd0, w_valid}, 32'd0);
        check("R7 word zero in reset", w_out, '0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R7 valid low after reset", {31'd0, w_valid}, 32'd0);

        // Steps while idle must be ignored (R5).
        step = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        step = 1'b0;
        check("R5 idle steps keep valid low", {31'd0, w_valid}, 32'd0);

        // Block 1: short-message pattern, gapped steps.
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0]  = 32'h61626380;
        blk[15] = 32'h00000018;
        load_block(1'b0, 1'b0);
        check("R3 known W16 value", ex[16], 32'hC2C4C700);
        run_steps(NS, 1'b1);
        end_checks();

        // Block 2: all ones, loaded with step held high (R6 priority).
        for (int i = 0; i < 16; i++) blk[i] = '1;
        load_block(1'b1, 1'b0);
        run_steps(NS, 1'b0);
        end_checks();

        // Block 3: counting words, restarted mid-run by block 4 (R6).
        for (int i = 0; i < 16; i++) blk[i] = W'(i) * 32'h01010101;
        load_block(1'b0, 1'b0);
        run_steps(30, 1'b1);
        lf = 32'hACE1_2468;
        for (int i = 0; i < 16; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            blk[i] = lf ^ (W'(i) << 24);
        end
        load_block(1'b0, 1'b1);
        run_steps(NS, 1'b1);
        end_checks();

        // Block 5: single set bit.
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = 32'h80000000;
        load_block(1'b0, 1'b0);
        run_steps(NS, 1'b0);
        end_checks();

        check("R5 all expected words consumed", W'(q.size()), '0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule